// File: doc/BRIEF.md
# Serial Configuration Port and Squelch Mode Decoder

This block is the digital control core of a sub-audible tone squelch front end. A host writes 8-bit frames over a three-wire serial port made of data, clock and strobe. Each frame holds a 2-bit address and a 6-bit payload. On the rising strobe the payload goes into one of four configuration registers. The serial lines are asynchronous to the system clock, so the block resynchronises them before it looks for edges.

From the stored configuration the block works out the operating mode: test, standby, voice-only, transmit or receive. It drives the receive-audio enable, an open-drain style detect pull-down, a transmit tone enable and the static control fields: transmit mute, tone phase, clock select, detector gain, tone level trim, route switches and the tone code. A `det_valid_i` input takes the place of the analog tone detector. The mode, audio, detect and tone-enable outputs are registered, so they follow their inputs by one system clock.

Top module: `sqc_ctrl_top`

## Requirements
- R1: Serial data is sampled on each rising edge of the serial clock, most significant bit first (address bit 1, address bit 0, then payload bits 5 to 0). A rising strobe writes the last 8 sampled bits, so any extra earlier bits have no effect.
- R2: Address 00 holds, from payload bit 5 down to bit 0: test-off, rx-off, phase, rx-on, rx/tx, standby. The phase bit drives `tone_phase_o`.
- R3: At address 01, payload bits 5:4 form a sub-address. Sub 00 loads {cdcss, fast-detect, tone-sum, limiter-bypass} from bits 3:0. Sub 01 loads {coarse, fine[4:3]} from bits 2:0. Sub 10 loads fine[2:0] from bits 2:0. Sub 11, and bit 3 of sub 10, change no output.
- R4: Address 10 payload {b5..b0} maps to gain[3]=b5, clock select=b4, tx mute=b3 and gain[2:0]=b2..b0.
- R5: Address 11 stores the 6-bit tone code, which appears on `tone_code_o`.
- R6: `mode_o` is 0 (test) when test-off=0. With test-off=1 it is 1 (standby) when standby=1 and rx-off=1, and 2 (voice) when standby=1 and rx-off=0. With test-off=1 and standby=0 it is 3 (transmit) when rx/tx=0 and 4 (receive) when rx/tx=1.
- R7: In receive mode `rx_audio_en_o` is 0 when rx-off=0 and 1 when rx-off=1 with rx-on=0. When rx-off=1 and rx-on=1 it equals the detect result: `det_valid_i` and a receive-valid tone code.
- R8: In transmit mode the audio enable is rx-off AND NOT rx-on. In voice mode it is rx/tx AND NOT rx-on. In standby and test mode it is 0.
- R9: In receive mode with a valid tone code, `det_pull_o` (1 = pull low) follows `det_valid_i` one clock later.
- R10: In receive mode a tone code outside 1..56 forces `det_pull_o` to 1. Code 57 is outside this range.
- R11: In test, standby, voice and transmit mode `det_pull_o` is 0 whatever `det_valid_i` is.
- R12: `tone_en_o` is 1 only in transmit mode with a tone code in 1..56, or code 57 with the cdcss bit set.
- R13: Synchronous reset gives the standby configuration (address 00 = 111111) with all other registers 0. Outputs: mode 1, every enable 0, code 0.
- R14: Serial clocks without a strobe change no register. A strobe alone writes whatever was shifted in last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_data_i | input | 1 | Serial data line, asynchronous |
| ser_clk_i | input | 1 | Serial bit clock, asynchronous |
| ser_stb_i | input | 1 | Serial strobe, rising edge writes |
| det_valid_i | input | 1 | Tone detector result |
| mode_o | output | 3 | Operating mode code |
| rx_audio_en_o | output | 1 | Receive audio enable |
| det_pull_o | output | 1 | Detect line pull-down enable |
| tx_mute_o | output | 1 | Transmit input mute |
| tone_phase_o | output | 1 | Transmit tone phase select |
| clk_sel_o | output | 1 | Master clock select |
| amp_gain_o | output | 4 | Detector amplifier gain code |
| tone_code_o | output | 6 | Selected tone code |
| tone_en_o | output | 1 | Transmit tone enable |
| cdcss_sel_o | output | 1 | Digital code squelch select |
| fast_det_o | output | 1 | Fast detection select |
| tone_sum_o | output | 1 | Internal tone summing enable |
| lim_bypass_o | output | 1 | Limiter and splatter bypass |
| lvl_coarse_o | output | 1 | Coarse tone level select |
| lvl_fine_o | output | 5 | Fine tone level code |

## Verification
The hardest case to reach is a detect output that is pulled low with no tone present. It needs receive mode together with a tone code outside the receive table. Code 57 is the subtle one, because it is legal for transmit with cdcss set. The stimulus first writes the receive control frame. It then rewrites only the tone register with codes 0, 56, 57 and 63 while `det_valid_i` stays low, and checks the pull-down after each write. The split level trim is spread over two sub-addresses, with test sub-addresses in between. It is brought out by writing each piece in turn and then a test frame, and reading the fine code back on its port.

// File: rtl/sqc_pkg.sv
package sqc_pkg;

    localparam int ADDR_W  = 2;
    localparam int DATA_W  = 6;
    localparam int FRAME_W = ADDR_W + DATA_W;
    localparam int GAIN_W  = 4;
    localparam int FINE_W  = 5;

    typedef enum logic [2:0] {
        MODE_TEST    = 3'd0,
        MODE_STANDBY = 3'd1,
        MODE_VOICE   = 3'd2,
        MODE_TX      = 3'd3,
        MODE_RX      = 3'd4
    } op_mode_e;

    typedef struct packed {
        logic tst_n;
        logic rxoff;
        logic phase;
        logic rxon;
        logic rxtx;
        logic stby;
    } ctl_reg_t;

    typedef struct packed {
        logic cdcss;
        logic fast;
        logic sum;
        logic bypass;
    } sw_reg_t;

    typedef struct packed {
        logic              coarse;
        logic [FINE_W-1:0] fine;
    } lvl_reg_t;

    typedef struct packed {
        logic [GAIN_W-1:0] gain;
        logic              cksel;
        logic              mute;
    } clk_reg_t;

    typedef struct packed {
        ctl_reg_t          ctl;
        sw_reg_t           sw;
        lvl_reg_t          lvl;
        clk_reg_t          ck;
        logic [DATA_W-1:0] tone;
    } cfg_t;

    function automatic cfg_t cfg_reset();
        cfg_t c;
        c      = '0;
        c.ctl  = '1;
        return c;
    endfunction

endpackage

// File: rtl/sqc_sync.sv
module sqc_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] pipe_d, pipe_q;

        if (STAGES == 1) begin : g_one
            always_comb pipe_d = async_i[b];
        end else begin : g_many
            always_comb pipe_d = {pipe_q[STAGES-2:0], async_i[b]};
        end

        always_ff @(posedge clk) begin
            if (rst) pipe_q <= '0;
            else     pipe_q <= pipe_d;
        end

        assign level_o[b] = pipe_q[STAGES-1];
    end
endmodule

// File: rtl/sqc_deser.sv
module sqc_deser
    import sqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sclk_i,
    input  logic               sdat_i,
    output logic [FRAME_W-1:0] frame_o
);
    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic               clk_prev;
    } deser_t;

    deser_t st_d, st_q;
    logic   shift_en;

    assign shift_en = sclk_i & ~st_q.clk_prev;

    always_comb begin
        st_d          = st_q;
        st_d.clk_prev = sclk_i;
        if (shift_en) st_d.frame = {st_q.frame[FRAME_W-2:0], sdat_i};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign frame_o = st_q.frame;

    // R1: the frame moves only on a serial clock rise
    a_r1_shift_only_on_edge: assert property (@(posedge clk) disable iff (rst)
        !(sclk_i && !st_q.clk_prev) |=> $stable(frame_o));
endmodule

// File: rtl/sqc_regfile.sv
module sqc_regfile
    import sqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               stb_i,
    input  logic [FRAME_W-1:0] frame_i,
    output cfg_t               cfg_o
);
    typedef struct packed {
        cfg_t cfg;
        logic stb_prev;
    } rf_t;

    localparam logic [1:0] A_CTL  = 2'b00;
    localparam logic [1:0] A_SW   = 2'b01;
    localparam logic [1:0] A_CLK  = 2'b10;
    localparam logic [1:0] A_TONE = 2'b11;

    rf_t                 st_d, st_q;
    logic                wr_en;
    logic [ADDR_W-1:0]   addr;
    logic [DATA_W-1:0]   data;

    assign wr_en = stb_i & ~st_q.stb_prev;
    assign addr  = frame_i[FRAME_W-1 -: ADDR_W];
    assign data  = frame_i[DATA_W-1:0];

    always_comb begin
        st_d          = st_q;
        st_d.stb_prev = stb_i;
        if (wr_en) begin
            unique case (addr)
                A_CTL:  st_d.cfg.ctl = ctl_reg_t'(data);
                A_SW: begin
                    unique case (data[5:4])
                        2'b00: st_d.cfg.sw = sw_reg_t'(data[3:0]);
                        2'b01: begin
                            st_d.cfg.lvl.coarse    = data[2];
                            st_d.cfg.lvl.fine[4:3] = data[1:0];
                        end
                        2'b10: st_d.cfg.lvl.fine[2:0] = data[2:0];
                        default: ;
                    endcase
                end
                A_CLK: begin
                    st_d.cfg.ck.gain  = {data[5], data[2:0]};
                    st_d.cfg.ck.cksel = data[4];
                    st_d.cfg.ck.mute  = data[3];
                end
                A_TONE: st_d.cfg.tone = data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cfg      <= cfg_reset();
            st_q.stb_prev <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o = st_q.cfg;

    // R14: no strobe rise, no register change
    a_r14_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
        !(stb_i && !st_q.stb_prev) |=> $stable(cfg_o));

    // R3: the test sub-address leaves every register alone
    a_r3_test_sub_ignored: assert property (@(posedge clk) disable iff (rst)
        (stb_i && !st_q.stb_prev && frame_i[7:4] == 4'b0111) |=> $stable(cfg_o));
endmodule

// File: rtl/sqc_mode_dec.sv
module sqc_mode_dec
    import sqc_pkg::*;
#(
    parameter int TONE_LAST   = 56,
    parameter int TONE_TXONLY = 57
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_reg_t          ctl_i,
    input  logic              cdcss_i,
    input  logic [DATA_W-1:0] tone_i,
    input  logic              det_valid_i,
    output op_mode_e          mode_o,
    output logic              audio_en_o,
    output logic              det_pull_o,
    output logic              tone_en_o
);
    localparam logic [DATA_W-1:0] LAST_C   = DATA_W'(TONE_LAST);
    localparam logic [DATA_W-1:0] TXONLY_C = DATA_W'(TONE_TXONLY);

    typedef struct packed {
        op_mode_e mode;
        logic     audio;
        logic     pull;
        logic     tone_en;
    } dec_t;

    dec_t     st_d, st_q;
    op_mode_e mode_c;
    logic     rx_ok, tx_ok, hit;

    always_comb begin
        rx_ok = (tone_i != '0) && (tone_i <= LAST_C);
        tx_ok = rx_ok || (tone_i == TXONLY_C && cdcss_i);
        hit   = det_valid_i && rx_ok;

        if (!ctl_i.tst_n)     mode_c = MODE_TEST;
        else if (ctl_i.stby)  mode_c = ctl_i.rxoff ? MODE_STANDBY : MODE_VOICE;
        else                  mode_c = ctl_i.rxtx ? MODE_RX : MODE_TX;

        st_d      = '0;
        st_d.mode = mode_c;
        unique case (mode_c)
            MODE_RX: begin
                st_d.audio = ctl_i.rxoff && (!ctl_i.rxon || hit);
                st_d.pull  = !rx_ok || det_valid_i;
            end
            MODE_TX: begin
                st_d.audio   = ctl_i.rxoff && !ctl_i.rxon;
                st_d.tone_en = tx_ok;
            end
            MODE_VOICE: st_d.audio = ctl_i.rxtx && !ctl_i.rxon;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            st_q.mode <= MODE_STANDBY;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o     = st_q.mode;
    assign audio_en_o = st_q.audio;
    assign det_pull_o = st_q.pull;
    assign tone_en_o  = st_q.tone_en;

    // R11: the detect line is released outside receive mode
    a_r11_release_outside_rx: assert property (@(posedge clk) disable iff (rst)
        (!ctl_i.tst_n || ctl_i.stby || !ctl_i.rxtx) |=> !det_pull_o);

    // R7: receive with rx-off clear keeps audio off
    a_r7_rx_audio_off: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.tst_n && !ctl_i.stby && ctl_i.rxtx && !ctl_i.rxoff) |=> !audio_en_o);

    // R12: tone enable only in transmit mode
    a_r12_tone_tx_only: assert property (@(posedge clk) disable iff (rst)
        (!ctl_i.tst_n || ctl_i.stby || ctl_i.rxtx) |=> !tone_en_o);

    // R10: receive mode with code zero pulls the line
    a_r10_zero_code_pulls: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.tst_n && !ctl_i.stby && ctl_i.rxtx && tone_i == '0) |=> det_pull_o);
endmodule

// File: rtl/sqc_ctrl_top.sv
module sqc_ctrl_top
    import sqc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TONE_LAST   = 56,
    parameter int TONE_TXONLY = 57
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_data_i,
    input  logic              ser_clk_i,
    input  logic              ser_stb_i,
    input  logic              det_valid_i,
    output logic [2:0]        mode_o,
    output logic              rx_audio_en_o,
    output logic              det_pull_o,
    output logic              tx_mute_o,
    output logic              tone_phase_o,
    output logic              clk_sel_o,
    output logic [GAIN_W-1:0] amp_gain_o,
    output logic [DATA_W-1:0] tone_code_o,
    output logic              tone_en_o,
    output logic              cdcss_sel_o,
    output logic              fast_det_o,
    output logic              tone_sum_o,
    output logic              lim_bypass_o,
    output logic              lvl_coarse_o,
    output logic [FINE_W-1:0] lvl_fine_o
);
    logic [2:0]         ser_s;
    logic [FRAME_W-1:0] frame;
    cfg_t               cfg;
    op_mode_e           mode;

    sqc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({ser_stb_i, ser_clk_i, ser_data_i}),
        .level_o (ser_s)
    );

    sqc_deser u_deser (
        .clk     (clk),
        .rst     (rst),
        .sclk_i  (ser_s[1]),
        .sdat_i  (ser_s[0]),
        .frame_o (frame)
    );

    sqc_regfile u_regs (
        .clk     (clk),
        .rst     (rst),
        .stb_i   (ser_s[2]),
        .frame_i (frame),
        .cfg_o   (cfg)
    );

    sqc_mode_dec #(.TONE_LAST(TONE_LAST), .TONE_TXONLY(TONE_TXONLY)) u_dec (
        .clk         (clk),
        .rst         (rst),
        .ctl_i       (cfg.ctl),
        .cdcss_i     (cfg.sw.cdcss),
        .tone_i      (cfg.tone),
        .det_valid_i (det_valid_i),
        .mode_o      (mode),
        .audio_en_o  (rx_audio_en_o),
        .det_pull_o  (det_pull_o),
        .tone_en_o   (tone_en_o)
    );

    assign mode_o       = mode;
    assign tx_mute_o    = cfg.ck.mute;
    assign clk_sel_o    = cfg.ck.cksel;
    assign amp_gain_o   = cfg.ck.gain;
    assign tone_phase_o = cfg.ctl.phase;
    assign tone_code_o  = cfg.tone;
    assign cdcss_sel_o  = cfg.sw.cdcss;
    assign fast_det_o   = cfg.sw.fast;
    assign tone_sum_o   = cfg.sw.sum;
    assign lim_bypass_o = cfg.sw.bypass;
    assign lvl_coarse_o = cfg.lvl.coarse;
    assign lvl_fine_o   = cfg.lvl.fine;
endmodule

// File: tb/sqc_ctrl_top_tb.sv
module sqc_ctrl_top_tb;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sdat = 1'b0, sclk = 1'b0, sstb = 1'b0, detv = 1'b0;
    logic [2:0] mode;
    logic audio, pull, mute, phase, cksel, tone_en, cdcss, fast, sum, byp, coarse;
    logic [3:0] gain;
    logic [5:0] code;
    logic [4:0] fine;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sqc_ctrl_top u_dut (
        .clk(clk), .rst(rst), .ser_data_i(sdat), .ser_clk_i(sclk), .ser_stb_i(sstb),
        .det_valid_i(detv), .mode_o(mode), .rx_audio_en_o(audio), .det_pull_o(pull),
        .tx_mute_o(mute), .tone_phase_o(phase), .clk_sel_o(cksel), .amp_gain_o(gain),
        .tone_code_o(code), .tone_en_o(tone_en), .cdcss_sel_o(cdcss), .fast_det_o(fast),
        .tone_sum_o(sum), .lim_bypass_o(byp), .lvl_coarse_o(coarse), .lvl_fine_o(fine)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [15:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            sdat = bits[i];
            idle(HALF);
            sclk = 1'b1;
            idle(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic strobe();
        idle(HALF);
        sstb = 1'b1;
        idle(HALF);
        sstb = 1'b0;
        idle(8);
    endtask

    task automatic wr(input logic [1:0] a, input logic [5:0] d);
        shift_bits({8'h00, a, d}, 8);
        strobe();
    endtask

    task automatic set_det(input logic v);
        detv = v;
        idle(3);
    endtask

    task automatic t_reset();
        chk("R13", "mode", mode, 1);
        chk("R13", "audio", audio, 0);
        chk("R13", "pull", pull, 0);
        chk("R13", "tone_en", tone_en, 0);
        chk("R13", "code", code, 0);
        chk("R13", "gain", gain, 0);
        chk("R13", "phase", phase, 1);
        chk("R13", "fine", fine, 0);
    endtask

    task automatic t_clk_reg();
        wr(2'b10, 6'b101101);
        chk("R4", "gain", gain, 13);
        chk("R4", "cksel", cksel, 0);
        chk("R4", "mute", mute, 1);
        wr(2'b10, 6'b010010);
        chk("R1", "gain", gain, 2);
        chk("R4", "cksel", cksel, 1);
        chk("R4", "mute", mute, 0);
    endtask

    task automatic t_modes();
        wr(2'b00, 6'b011111); chk("R6", "test", mode, 0);
        wr(2'b00, 6'b111001); chk("R6", "standby", mode, 1);
        chk("R2", "phase", phase, 1);
        wr(2'b00, 6'b100001); chk("R6", "voice", mode, 2);
        chk("R2", "phase", phase, 0);
        wr(2'b00, 6'b110000); chk("R6", "tx", mode, 3);
        wr(2'b00, 6'b110010); chk("R6", "rx", mode, 4);
    endtask

    task automatic t_rx_audio();
        wr(2'b11, 6'd5);
        chk("R5", "code", code, 5);
        wr(2'b00, 6'b100010); chk("R7", "rxoff0", audio, 0);
        wr(2'b00, 6'b110010); chk("R7", "forced on", audio, 1);
        wr(2'b00, 6'b110110);
        set_det(1'b0); chk("R7", "follow idle", audio, 0);
        set_det(1'b1); chk("R7", "follow hit", audio, 1);
        set_det(1'b0);
    endtask

    task automatic t_other_audio();
        wr(2'b00, 6'b110000); chk("R8", "tx on", audio, 1);
        wr(2'b00, 6'b110100); chk("R8", "tx off", audio, 0);
        wr(2'b00, 6'b100011); chk("R8", "voice on", audio, 1);
        wr(2'b00, 6'b100111); chk("R8", "voice off", audio, 0);
        wr(2'b00, 6'b111111); chk("R8", "standby", audio, 0);
    endtask

    task automatic t_detect();
        wr(2'b11, 6'd5);
        wr(2'b00, 6'b110010);
        set_det(1'b0); chk("R9", "no tone", pull, 0);
        set_det(1'b1); chk("R9", "tone", pull, 1);
        set_det(1'b0); chk("R9", "tone gone", pull, 0);
    endtask

    task automatic t_invalid();
        wr(2'b00, 6'b110010);
        set_det(1'b0);
        wr(2'b11, 6'd0);  chk("R10", "code 0", pull, 1);
        wr(2'b11, 6'd56); chk("R10", "code 56", pull, 0);
        wr(2'b11, 6'd57); chk("R10", "code 57", pull, 1);
        wr(2'b11, 6'd63); chk("R10", "code 63", pull, 1);
    endtask

    task automatic t_nonrx();
        wr(2'b11, 6'd5);
        set_det(1'b1);
        wr(2'b00, 6'b110000); chk("R11", "tx", pull, 0);
        wr(2'b00, 6'b100001); chk("R11", "voice", pull, 0);
        wr(2'b00, 6'b111111); chk("R11", "standby", pull, 0);
        wr(2'b00, 6'b011110); chk("R11", "test", pull, 0);
        set_det(1'b0);
    endtask

    task automatic t_tone_en();
        wr(2'b01, 6'b000000);
        wr(2'b00, 6'b110000);
        wr(2'b11, 6'd5);  chk("R12", "tx valid", tone_en, 1);
        wr(2'b11, 6'd57); chk("R12", "57 no cdcss", tone_en, 0);
        wr(2'b01, 6'b001000);
        chk("R3", "cdcss", cdcss, 1);
        chk("R12", "57 cdcss", tone_en, 1);
        wr(2'b11, 6'd0);  chk("R12", "code 0", tone_en, 0);
        wr(2'b11, 6'd5);
        wr(2'b00, 6'b110010); chk("R12", "rx", tone_en, 0);
    endtask

    task automatic t_sub();
        wr(2'b01, 6'b000111);
        chk("R3", "cdcss", cdcss, 0);
        chk("R3", "fast", fast, 1);
        chk("R3", "sum", sum, 1);
        chk("R3", "bypass", byp, 1);
        wr(2'b01, 6'b010101);
        chk("R3", "coarse", coarse, 1);
        chk("R3", "fine hi", fine, 8);
        wr(2'b01, 6'b101110);
        chk("R3", "fine", fine, 14);
        wr(2'b01, 6'b111111);
        chk("R3", "sub11 fine", fine, 14);
        chk("R3", "sub11 coarse", coarse, 1);
        chk("R3", "sub11 cdcss", cdcss, 0);
        chk("R3", "sub11 fast", fast, 1);
    endtask

    task automatic t_extra_bits();
        shift_bits({6'b0, 2'b10, 2'b11, 6'd42}, 10);
        strobe();
        chk("R1", "extra bits", code, 42);
    endtask

    task automatic t_no_strobe();
        shift_bits({8'h00, 2'b11, 6'd17}, 8);
        idle(12);
        chk("R14", "no strobe", code, 42);
        strobe();
        chk("R14", "strobe only", code, 17);
    endtask

    initial begin
        idle(4);
        rst = 1'b0;
        idle(3);
        t_reset();
        t_clk_reg();
        t_modes();
        t_rx_audio();
        t_other_audio();
        t_detect();
        t_invalid();
        t_nonrx();
        t_tone_en();
        t_sub();
        t_extra_bits();
        t_no_strobe();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule